// File: doc/BRIEF.md
# GPIO Port Controller

A sixteen-pin general-purpose I/O port controller with a small word-addressed register bus. Software programs a two-bit mode, a one-bit drive type, a two-bit pull selection and a two-bit slew setting per pin. From these fields and an output data register the block produces every pad control signal: output enable, output value, open-drain flag, pull-up and pull-down enables, input-buffer enable, alternate-function select and a per-pin speed code. Pin levels pass through a two-flop synchronizer and can be read back from an input register.

Software can change individual output bits with one bus write to a write-only set/clear register. Because no read-modify-write sequence is involved, no interrupt handler can corrupt the result between a read and its write-back. Every register accepts word, half-word and byte writes through four byte-lane enables.

Top module: `gpio_bank`

## Requirements
- R1: After reset every mode, type, pull, speed and output data field is zero, so all pins are digital inputs: padOe, padPuEn and padPdEn are all 0, padIe is all 1 and every register reads 0.
- R2: Word indices: 0 mode (2 bits per pin, pin i at bits 2i+1:2i), 1 drive type (bit i), 2 speed (2 bits per pin), 3 pull (2 bits per pin), 4 input data, 5 output data (bit i), 6 set/clear. On a write to 0, 1, 2, 3 or 5, busBe[b] set means bits 8b+7:8b are written and the other bits keep their value.
- R3: A write to word 6 sets output bit i when data bit i is 1 and clears it when data bit 16+i is 1, each only in an enabled byte lane. If both are 1 the bit ends up set. Word 6 reads as 0.
- R4: Mode codes are 00 input, 01 output, 10 alternate function and 11 analog. In output mode with drive type 0 (push-pull), padOe is 1. padOut always carries the output data bit.
- R5: With drive type 1 (open-drain), padOdEn is 1 in output and alternate mode. In output mode padOe is 1 only while the output data bit is 0.
- R6: Pull code 01 sets padPuEn, 10 sets padPdEn, and 00 or the reserved 11 enables neither. Pull-up and pull-down are never both active.
- R7: In analog mode padOe, padPuEn, padPdEn and padIe are all 0, and the pin's input data bit reads 0.
- R8: padAltSel is 1 exactly in alternate mode. There the block leaves padOe at 0 and keeps padIe at 1.
- R9: padSpeed carries the speed register, pin i at bits 2i+1:2i.
- R10: Input data bit i shows pin i two clock edges after it changes (still the old value after one edge). Writes to word 4 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| busSel | input | 1 | Bus access in this cycle |
| busWr | input | 1 | 1 write, 0 read |
| busWordAddr | input | 3 | Register word index |
| busBe | input | 4 | Byte-lane enables for writes |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the index |
| pinIn | input | 16 | Raw pin levels |
| padOe | output | 16 | Pad output driver enable |
| padOut | output | 16 | Pad output value |
| padOdEn | output | 16 | Open-drain drive |
| padPuEn | output | 16 | Pull-up enable |
| padPdEn | output | 16 | Pull-down enable |
| padIe | output | 16 | Digital input buffer enable |
| padAltSel | output | 16 | Route pad to the alternate function |
| padSpeed | output | 32 | Per-pin speed code |

## Verification
The assertions check on every cycle that the pad controls stay consistent: pull-up and pull-down are never both on, nothing drives or pulls a pin whose input buffer is off, an enabled open-drain pin never drives a 1, and alternate pins neither drive from the block nor lose their input buffer. They also check the set/clear outcome, the zero read-back of that register, the quiet pads after reset and the two-edge input latency. The bench scenarios cover what those invariants cannot show: each lane-enable pattern against each writable register, every mode, type, pull and data combination decoded to exact pad values, the set-over-clear priority and that writes to the input register have no effect.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int BUS_W   = 32;
  localparam int LANES   = BUS_W / 8;
  localparam int WIDX_W  = 3;

  typedef enum logic [1:0] {
    MODE_IN  = 2'b00,
    MODE_OUT = 2'b01,
    MODE_ALT = 2'b10,
    MODE_ANA = 2'b11
  } pinMode_e;

  typedef enum logic [1:0] {
    PULL_NONE = 2'b00,
    PULL_UP   = 2'b01,
    PULL_DOWN = 2'b10,
    PULL_RSVD = 2'b11
  } pullSel_e;

  localparam logic [WIDX_W-1:0] IDX_MODE   = 3'd0;
  localparam logic [WIDX_W-1:0] IDX_TYPE   = 3'd1;
  localparam logic [WIDX_W-1:0] IDX_SPEED  = 3'd2;
  localparam logic [WIDX_W-1:0] IDX_PULL   = 3'd3;
  localparam logic [WIDX_W-1:0] IDX_IN     = 3'd4;
  localparam logic [WIDX_W-1:0] IDX_OUT    = 3'd5;
  localparam logic [WIDX_W-1:0] IDX_SETCLR = 3'd6;

  typedef struct packed {
    logic              wrMode;
    logic              wrType;
    logic              wrSpeed;
    logic              wrPull;
    logic              wrOut;
    logic              wrSetClr;
    logic [BUS_W-1:0]  laneMask;
    logic [WIDX_W-1:0] rdIdx;
  } busStrobe_t;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic              busSel,
  input  logic              busWr,
  input  logic [WIDX_W-1:0] busWordAddr,
  input  logic [LANES-1:0]  busBe,
  output busStrobe_t        strobe
);

  logic wrHit;
  logic [BUS_W-1:0] laneMask;

  assign wrHit = busSel && busWr;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign laneMask[8*b +: 8] = {8{busBe[b]}};
  end

  always_comb begin
    strobe          = '0;
    strobe.laneMask = laneMask;
    strobe.rdIdx    = busWordAddr;
    if (wrHit) begin
      unique case (busWordAddr)
        IDX_MODE:   strobe.wrMode   = 1'b1;
        IDX_TYPE:   strobe.wrType   = 1'b1;
        IDX_SPEED:  strobe.wrSpeed  = 1'b1;
        IDX_PULL:   strobe.wrPull   = 1'b1;
        IDX_OUT:    strobe.wrOut    = 1'b1;
        IDX_SETCLR: strobe.wrSetClr = 1'b1;
        default:    ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int PINS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strobe,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic [PINS-1:0]   pinIn,
  output logic [PINS-1:0]   padOe,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOdEn,
  output logic [PINS-1:0]   padPuEn,
  output logic [PINS-1:0]   padPdEn,
  output logic [PINS-1:0]   padIe,
  output logic [PINS-1:0]   padAltSel,
  output logic [2*PINS-1:0] padSpeed
);

  localparam int FW    = 2 * PINS;
  localparam int CLR_LO = BUS_W / 2;

  logic [FW-1:0]   modeQ, speedQ, pullQ;
  logic [PINS-1:0] typeQ, outQ;
  logic [PINS-1:0] syncA, syncB;
  logic [PINS-1:0] setBits, clrBits;
  logic [PINS-1:0] inView;

  logic [FW-1:0]   m2;
  logic [PINS-1:0] m1;
  assign m2 = strobe.laneMask[FW-1:0];
  assign m1 = strobe.laneMask[PINS-1:0];

  assign setBits = busWdata[PINS-1:0] & strobe.laneMask[PINS-1:0];
  assign clrBits = busWdata[CLR_LO +: PINS] & strobe.laneMask[CLR_LO +: PINS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= '0;
      typeQ  <= '0;
      speedQ <= '0;
      pullQ  <= '0;
      outQ   <= '0;
    end else begin
      if (strobe.wrMode)  modeQ  <= (modeQ  & ~m2) | (busWdata[FW-1:0]   & m2);
      if (strobe.wrType)  typeQ  <= (typeQ  & ~m1) | (busWdata[PINS-1:0] & m1);
      if (strobe.wrSpeed) speedQ <= (speedQ & ~m2) | (busWdata[FW-1:0]   & m2);
      if (strobe.wrPull)  pullQ  <= (pullQ  & ~m2) | (busWdata[FW-1:0]   & m2);
      if (strobe.wrOut)
        outQ <= (outQ & ~m1) | (busWdata[PINS-1:0] & m1);
      else if (strobe.wrSetClr)
        outQ <= (outQ & ~clrBits) | setBits;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic [1:0] pm;
    logic [1:0] pl;
    logic isOut, isAlt, isAna;
    assign pm    = modeQ[2*i +: 2];
    assign pl    = pullQ[2*i +: 2];
    assign isOut = (pm == MODE_OUT);
    assign isAlt = (pm == MODE_ALT);
    assign isAna = (pm == MODE_ANA);

    assign padOe[i]     = isOut && (!typeQ[i] || !outQ[i]);
    assign padOdEn[i]   = typeQ[i] && (isOut || isAlt);
    assign padPuEn[i]   = !isAna && (pl == PULL_UP);
    assign padPdEn[i]   = !isAna && (pl == PULL_DOWN);
    assign padIe[i]     = !isAna;
    assign padAltSel[i] = isAlt;
    assign inView[i]    = syncB[i] && !isAna;
  end

  assign padOut   = outQ;
  assign padSpeed = speedQ;

  always_comb begin
    busRdata = '0;
    unique case (strobe.rdIdx)
      IDX_MODE:  busRdata[FW-1:0]   = modeQ;
      IDX_TYPE:  busRdata[PINS-1:0] = typeQ;
      IDX_SPEED: busRdata[FW-1:0]   = speedQ;
      IDX_PULL:  busRdata[FW-1:0]   = pullQ;
      IDX_IN:    busRdata[PINS-1:0] = inView;
      IDX_OUT:   busRdata[PINS-1:0] = outQ;
      default:   busRdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int PINS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [2:0]        busWordAddr,
  input  logic [3:0]        busBe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [PINS-1:0]   pinIn,
  output logic [PINS-1:0]   padOe,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOdEn,
  output logic [PINS-1:0]   padPuEn,
  output logic [PINS-1:0]   padPdEn,
  output logic [PINS-1:0]   padIe,
  output logic [PINS-1:0]   padAltSel,
  output logic [2*PINS-1:0] padSpeed
);

  busStrobe_t strobe;

  gpio_bank_ctrl u_ctrl (
    .busSel      (busSel),
    .busWr       (busWr),
    .busWordAddr (busWordAddr),
    .busBe       (busBe),
    .strobe      (strobe)
  );

  gpio_bank_dp #(.PINS(PINS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .pinIn     (pinIn),
    .padOe     (padOe),
    .padOut    (padOut),
    .padOdEn   (padOdEn),
    .padPuEn   (padPuEn),
    .padPdEn   (padPdEn),
    .padIe     (padIe),
    .padAltSel (padAltSel),
    .padSpeed  (padSpeed)
  );

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int PINS = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            busSel,
  input logic            busWr,
  input logic [2:0]      busWordAddr,
  input logic [3:0]      busBe,
  input logic [31:0]     busWdata,
  input logic [31:0]     busRdata,
  input logic [PINS-1:0] pinIn,
  input logic [PINS-1:0] padOe,
  input logic [PINS-1:0] padOut,
  input logic [PINS-1:0] padOdEn,
  input logic [PINS-1:0] padPuEn,
  input logic [PINS-1:0] padPdEn,
  input logic [PINS-1:0] padIe,
  input logic [PINS-1:0] padAltSel
);

  logic [1:0] sinceRst;
  always_ff @(posedge clk) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (padOe == '0 && padIe == '1 && padPuEn == '0 && padPdEn == '0));

  p_setclr_result_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busWordAddr == 3'd6 && busBe == 4'hF) |=>
      padOut == (($past(padOut) & ~$past(busWdata[16 +: PINS])) | $past(busWdata[PINS-1:0])));

  p_setclr_reads_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busWordAddr == 3'd6) |-> busRdata == '0);

  p_od_never_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & padOdEn & padOut) == '0);

  p_pull_exclusive_r6: assert property (@(posedge clk) disable iff (!rstN)
    (padPuEn & padPdEn) == '0);

  p_analog_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((padOe | padPuEn | padPdEn) & ~padIe) == '0);

  p_alt_handoff_r8: assert property (@(posedge clk) disable iff (!rstN)
    (padAltSel & (padOe | ~padIe)) == '0);

  p_input_sync_r10: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && busSel && !busWr && busWordAddr == 3'd4) |->
      busRdata[PINS-1:0] == ($past(pinIn, 2) & padIe));

endmodule

bind gpio_bank gpio_bank_chk #(.PINS(PINS)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busSel      (busSel),
  .busWr       (busWr),
  .busWordAddr (busWordAddr),
  .busBe       (busBe),
  .busWdata    (busWdata),
  .busRdata    (busRdata),
  .pinIn       (pinIn),
  .padOe       (padOe),
  .padOut      (padOut),
  .padOdEn     (padOdEn),
  .padPuEn     (padPuEn),
  .padPdEn     (padPdEn),
  .padIe       (padIe),
  .padAltSel   (padAltSel)
);

// File: tb/gpio_bank_bench.sv
`timescale 1ns/1ps
module gpio_bank_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [2:0]  busWordAddr = '0;
  logic [3:0]  busBe = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [15:0] pinIn = '0;
  logic [15:0] padOe, padOut, padOdEn, padPuEn, padPdEn, padIe, padAltSel;
  logic [31:0] padSpeed;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] mdl [0:7];

  always #4 clk = ~clk;

  gpio_bank u_gpio_bank (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busWordAddr(busWordAddr), .busBe(busBe), .busWdata(busWdata),
    .busRdata(busRdata), .pinIn(pinIn), .padOe(padOe), .padOut(padOut),
    .padOdEn(padOdEn), .padPuEn(padPuEn), .padPdEn(padPdEn), .padIe(padIe),
    .padAltSel(padAltSel), .padSpeed(padSpeed)
  );

  function automatic logic [31:0] laneMask(input logic [3:0] be);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{be[b]}};
    return m;
  endfunction

  function automatic logic [31:0] regWidth(input int idx);
    return (idx == 0 || idx == 2 || idx == 3) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input int idx, input logic [31:0] d, input logic [3:0] be);
    logic [31:0] m;
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busWordAddr = idx[2:0]; busWdata = d; busBe = be;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
    m = laneMask(be);
    if (idx == 6) begin
      mdl[5] = ((mdl[5] & ~((d & m) >> 16)) | (d & m)) & 32'hFFFF;
    end else if (idx != 4 && idx != 7) begin
      mdl[idx] = ((mdl[idx] & ~m) | (d & m)) & regWidth(idx);
    end
  endtask

  task automatic readNow(input int idx, output logic [31:0] d);
    busSel = 1'b1; busWr = 1'b0; busWordAddr = idx[2:0];
    #1 d = busRdata;
  endtask

  task automatic busRead(input int idx, output logic [31:0] d);
    @(negedge clk);
    readNow(idx, d);
  endtask

  task automatic checkPads(input string tagSfx);
    logic [15:0] eOe, eOd, ePu, ePd, eIe, eAlt;
    for (int i = 0; i < 16; i++) begin
      logic [1:0] m, p;
      logic t, o;
      m = mdl[0][2*i +: 2]; p = mdl[3][2*i +: 2]; t = mdl[1][i]; o = mdl[5][i];
      eOe[i]  = (m == 2'd1) && (!t || !o);
      eOd[i]  = t && (m == 2'd1 || m == 2'd2);
      ePu[i]  = (m != 2'd3) && (p == 2'd1);
      ePd[i]  = (m != 2'd3) && (p == 2'd2);
      eIe[i]  = (m != 2'd3);
      eAlt[i] = (m == 2'd2);
    end
    check({"R4/R5 padOe ", tagSfx}, {16'h0, padOe}, {16'h0, eOe});
    check({"R4 padOut ", tagSfx}, {16'h0, padOut}, mdl[5]);
    check({"R5 padOdEn ", tagSfx}, {16'h0, padOdEn}, {16'h0, eOd});
    check({"R6 padPuEn ", tagSfx}, {16'h0, padPuEn}, {16'h0, ePu});
    check({"R6 padPdEn ", tagSfx}, {16'h0, padPdEn}, {16'h0, ePd});
    check({"R7 padIe ", tagSfx}, {16'h0, padIe}, {16'h0, eIe});
    check({"R8 padAltSel ", tagSfx}, {16'h0, padAltSel}, {16'h0, eAlt});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    for (int k = 0; k < 8; k++) mdl[k] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      busRead(k, rd);
      check($sformatf("R1 reset read idx %0d", k), rd, 32'h0);
    end
    checkPads("R1 reset");

    // R2: byte-lane writes on every writable register
    for (int r = 0; r < 6; r++) begin
      if (r == 4) continue;
      for (int be = 0; be < 16; be++) begin
        logic [31:0] pat;
        pat = 32'h9E37_79B9 * (be + 1) ^ (32'h5A5A_0F0F << r);
        busWrite(r, pat, be[3:0]);
        busRead(r, rd);
        check($sformatf("R2 lanes reg %0d be %h", r, be), rd, mdl[r]);
      end
    end

    // R3: set/clear with lane enables, priority and zero read-back
    for (int be = 0; be < 16; be++) begin
      logic [31:0] w;
      busWrite(5, 32'h0000_3C5A ^ (be * 32'h0111), 4'hF);
      w = (be[0]) ? 32'hF0F0_FF00 : 32'h0FF0_00F3;
      w = w ^ (be * 32'h1357_2468);
      busWrite(6, w, be[3:0]);
      busRead(5, rd);
      check($sformatf("R3 set/clear be %h", be), rd, mdl[5]);
      busRead(6, rd);
      check("R3 set/clear reads zero", rd, 32'h0);
    end
    busWrite(5, 32'h0000_00FF, 4'hF);
    busWrite(6, 32'hFFFF_FFFF, 4'hF);
    busRead(5, rd);
    check("R3 set wins over clear", rd, 32'h0000_FFFF);

    // R4-R8: decode sweep; pin i gets combination (c+i) mod 64
    for (int c = 0; c < 64; c++) begin
      logic [31:0] mv, pv;
      logic [15:0] tv, ov;
      for (int i = 0; i < 16; i++) begin
        logic [5:0] v;
        v = 6'(c + i);
        mv[2*i +: 2] = v[1:0];
        tv[i] = v[2];
        pv[2*i +: 2] = v[4:3];
        ov[i] = v[5];
      end
      busWrite(0, mv, 4'hF);
      busWrite(1, {16'h0, tv}, 4'hF);
      busWrite(3, pv, 4'hF);
      busWrite(5, {16'h0, ov}, 4'hF);
      checkPads($sformatf("combo %0d", c));
    end

    // R9: speed field to pads
    for (int s = 0; s < 8; s++) begin
      busWrite(2, 32'hC6A4_A793 * (s + 3), 4'hF);
      check($sformatf("R9 padSpeed pattern %0d", s), padSpeed, mdl[2]);
    end

    // R10 / R7: input synchronizer, analog masking, ignored writes
    busWrite(0, 32'h0, 4'hF);
    for (int v = 0; v < 6; v++) begin
      logic [15:0] oldV, newV;
      oldV = pinIn;
      newV = 16'hA5C3 ^ 16'(v * 16'h1F31);
      @(negedge clk);
      pinIn = newV;
      @(negedge clk);
      readNow(4, rd);
      check($sformatf("R10 one edge keeps old %0d", v), rd, {16'h0, oldV});
      @(negedge clk);
      readNow(4, rd);
      check($sformatf("R10 two edges show new %0d", v), rd, {16'h0, newV});
    end
    @(negedge clk);
    pinIn = 16'hFFFF;
    busWrite(0, 32'h0000_00FF, 4'hF);
    busWrite(0, 32'h0000_00FF, 4'hF);
    busRead(4, rd);
    check("R7 analog pins read zero", rd, 32'h0000_FFF0);
    busWrite(4, 32'h0000_0000, 4'hF);
    busRead(4, rd);
    check("R10 write to input ignored", rd, 32'h0000_FFF0);
    for (int k = 0; k < 8; k++) begin
      if (k == 4) continue;
      busRead(k, rd);
      check($sformatf("R10 other regs untouched idx %0d", k), rd, (k == 6 || k == 7) ? 32'h0 : mdl[k]);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule